// File: doc/BRIEF.md
# Cascaded Cell Staircase Level Modulator

This block turns a signed, digitised per-phase voltage reference into a discrete output level for a stack of series-connected H-bridge cells, and issues a three-state command to each cell so that the summed cell voltages follow the reference in equal steps. One reference sample is taken on every clock. It is quantised against thresholds placed halfway between adjacent levels, and the resulting level is spread over the cells in stacking order. Cells join the stack as the magnitude rises and leave it, last-in first-out, as the magnitude falls.

A switching guard watches the direction of each accepted level change. If the level tries to move back against the previous change within a programmable window, the block holds every cell in its present state for a programmable number of clocks. This stops a reference that dithers near a threshold from toggling cells repeatedly. The level never jumps straight from a positive value to a negative one or the reverse. Such a move passes through zero for one update, so each cell moves only between zero and one polarity.

Top module: `chb_stair_mod`

## Requirements
- R1: With the guard disabled (`min_gap` = 0), the level is floor((|ref| + STEP/2) / STEP), carrying the sign of `ref_in`. A reference that lies exactly halfway between two levels rounds away from zero; with the defaults (STEP = 400), a reference of 200 gives level 1. The level appears on `level` one clock edge after the sample is taken.
- R2: The level saturates at +N_CELLS and -N_CELLS (±12 by default) for any reference beyond full scale, including the most negative input code.
- R3: The level may change by any number of steps in a single update; for example, 0 to +12 in one clock.
- R4: For a level of +k, cells 0 to k-1 carry code 01 (positive) and all other cells carry 00 (zero). For -k, cells 0 to k-1 carry 10 (negative). Cell i occupies bits [2i+1:2i] of `cell_cmd`, and all cells are updated on the same clock edge as `level`.
- R5: When the quantised target has the opposite sign to the present nonzero level, the level goes to 0 on that update and continues to the target on the next one. No cell ever moves directly between 01 and 10.
- R6: A level move opposite in direction to the last accepted move is a reversal when it falls within `min_gap` clock edges of that move. A reversal is not applied. Instead, `frozen` is high for `hold_cycles` sampled cycles and the level and cells stay unchanged whatever the reference does. The first update after `frozen` falls is skipped, and the level is accepted on the update after that.
- R7: A move opposite to the last accepted move that arrives `min_gap`+1 or more clock edges after that move is applied at once, without freezing.
- R8: A synchronous active-high reset sets `level` to 0, all cell codes to 00, and `frozen` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | REF_W | Signed reference sample, one LSB per volt |
| hold_cycles | input | TMR_W | Number of clocks the cells stay frozen after a reversal |
| min_gap | input | TMR_W | Reversal window in clock edges after an accepted move; 0 disables the guard |
| level | output | LVL_W | Signed present output level, in steps |
| cell_cmd | output | 2*N_CELLS | Per-cell command, 2 bits each: 00 zero, 01 positive, 10 negative |
| frozen | output | 1 | High while the reversal guard holds the cells |

## Verification
A wrong cell map or a broken stacking order shows up on the same edge that `level` changes: the count of nonzero cell codes stops matching |level|, or a gap appears in the run of active cells. A fault in the guard's direction memory or its gap counter either lets a dithering reference through on the very next update, or freezes a legitimate move. The bench therefore places reversals at exactly `min_gap` and at `min_gap`+1 edges after an accepted move. A miscounted freeze timer moves the edge where `frozen` falls and the edge where the held move is finally taken by at least one clock, and the bench samples on each of those clocks.

// File: rtl/chb_pkg.sv
package chb_pkg;
   typedef enum logic [1:0] {
      CELL_ZERO = 2'b00,
      CELL_POS  = 2'b01,
      CELL_NEG  = 2'b10
   } cell_code_e;
endpackage

// File: rtl/chb_quant.sv
module chb_quant #(
   parameter int REF_W   = 16,
   parameter int STEP    = 400,
   parameter int N_CELLS = 12,
   parameter int LVL_W   = 5
) (
   input  logic signed [REF_W-1:0] ref_in,
   output logic signed [LVL_W-1:0] target
);
   localparam int HALF = STEP / 2;

   int ref_i;
   int mag_i;
   int k_i;

   // Midpoint thresholds: round half away from zero, then clamp to the stack height.
   always_comb begin
      ref_i = int'(ref_in);
      mag_i = (ref_i < 0) ? -ref_i : ref_i;
      k_i   = (mag_i + HALF) / STEP;
      if (k_i > N_CELLS) k_i = N_CELLS;
      target = LVL_W'((ref_i < 0) ? -k_i : k_i);
   end
endmodule

// File: rtl/chb_guard.sv
module chb_guard #(
   parameter int N_CELLS = 12,
   parameter int LVL_W   = 5,
   parameter int TMR_W   = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [LVL_W-1:0] target,
   input  logic [TMR_W-1:0]        hold_cycles,
   input  logic [TMR_W-1:0]        min_gap,
   output logic signed [LVL_W-1:0] level_q,
   output logic signed [LVL_W-1:0] level_nxt,
   output logic                    frozen
);
   localparam logic [TMR_W-1:0] GAP_MAX = '1;

   logic [TMR_W-1:0]        frz_cnt, frz_nxt;
   logic [TMR_W-1:0]        gap_cnt, gap_nxt;
   logic                    last_up, last_dn, up_nxt, dn_nxt;
   logic signed [LVL_W-1:0] want;
   logic                    moving, going_up, going_dn, is_rev, accept;

   // Opposite-sign targets pass through zero first.
   always_comb begin
      want = target;
      if ((level_q > 0 && target < 0) || (level_q < 0 && target > 0))
         want = '0;
   end

   assign moving   = (want != level_q);
   assign going_up = (want > level_q);
   assign going_dn = (want < level_q);
   assign is_rev   = moving && ((going_up && last_dn) || (going_dn && last_up))
                     && (gap_cnt < min_gap);
   assign accept   = (frz_cnt == '0) && moving && !is_rev;

   always_comb begin
      level_nxt = level_q;
      frz_nxt   = frz_cnt;
      up_nxt    = last_up;
      dn_nxt    = last_dn;
      gap_nxt   = (gap_cnt == GAP_MAX) ? gap_cnt : gap_cnt + 1'b1;
      if (frz_cnt != '0) begin
         frz_nxt = frz_cnt - 1'b1;
      end else if (is_rev) begin
         frz_nxt = hold_cycles;
         up_nxt  = 1'b0;
         dn_nxt  = 1'b0;
      end else if (accept) begin
         level_nxt = want;
         up_nxt    = going_up;
         dn_nxt    = going_dn;
         gap_nxt   = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= '0;
         frz_cnt <= '0;
         gap_cnt <= GAP_MAX;
         last_up <= 1'b0;
         last_dn <= 1'b0;
      end else begin
         level_q <= level_nxt;
         frz_cnt <= frz_nxt;
         gap_cnt <= gap_nxt;
         last_up <= up_nxt;
         last_dn <= dn_nxt;
      end
   end

   assign frozen = (frz_cnt != '0);
endmodule

// File: rtl/chb_cells.sv
module chb_cells
   import chb_pkg::*;
#(
   parameter int N_CELLS = 12,
   parameter int LVL_W   = 5
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [LVL_W-1:0] level_nxt,
   output logic [2*N_CELLS-1:0]    cell_cmd
);
   for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_cell
      localparam int IDX = gi;
      cell_code_e code_q;
      always_ff @(posedge clk) begin
         if (rst)                          code_q <= CELL_ZERO;
         else if (int'(level_nxt) > IDX)   code_q <= CELL_POS;
         else if (int'(level_nxt) < -IDX)  code_q <= CELL_NEG;
         else                              code_q <= CELL_ZERO;
      end
      assign cell_cmd[2*gi +: 2] = code_q;
   end
endmodule

// File: rtl/chb_stair_mod.sv
module chb_stair_mod #(
   parameter int N_CELLS = 12,
   parameter int REF_W   = 16,
   parameter int STEP    = 400,
   parameter int TMR_W   = 16,
   localparam int LVL_W  = $clog2(N_CELLS + 1) + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic [TMR_W-1:0]        hold_cycles,
   input  logic [TMR_W-1:0]        min_gap,
   output logic signed [LVL_W-1:0] level,
   output logic [2*N_CELLS-1:0]    cell_cmd,
   output logic                    frozen
);
   if (N_CELLS < 1 || N_CELLS > 64) begin : g_bad_cells
      $error("chb_stair_mod: N_CELLS out of range");
   end
   if (STEP < 2) begin : g_bad_step
      $error("chb_stair_mod: STEP must be at least 2");
   end
   if (REF_W < 2 || REF_W > 30) begin : g_bad_ref
      $error("chb_stair_mod: REF_W out of range");
   end
   if (TMR_W < 1 || TMR_W > 31) begin : g_bad_tmr
      $error("chb_stair_mod: TMR_W out of range");
   end

   logic signed [LVL_W-1:0] target;
   logic signed [LVL_W-1:0] level_nxt;

   chb_quant #(.REF_W(REF_W), .STEP(STEP), .N_CELLS(N_CELLS), .LVL_W(LVL_W)) u_quant (
      .ref_in (ref_in),
      .target (target)
   );

   chb_guard #(.N_CELLS(N_CELLS), .LVL_W(LVL_W), .TMR_W(TMR_W)) u_guard (
      .clk         (clk),
      .rst         (rst),
      .target      (target),
      .hold_cycles (hold_cycles),
      .min_gap     (min_gap),
      .level_q     (level),
      .level_nxt   (level_nxt),
      .frozen      (frozen)
   );

   chb_cells #(.N_CELLS(N_CELLS), .LVL_W(LVL_W)) u_cells (
      .clk       (clk),
      .rst       (rst),
      .level_nxt (level_nxt),
      .cell_cmd  (cell_cmd)
   );
endmodule

// File: rtl/chb_stair_mod_chk.sv
module chb_stair_mod_chk #(
   parameter int N_CELLS = 12,
   parameter int LVL_W   = 5
) (
   input logic                    clk,
   input logic                    rst,
   input logic signed [LVL_W-1:0] level,
   input logic [2*N_CELLS-1:0]    cell_cmd,
   input logic                    frozen
);
   int nz_cnt;
   int lvl_abs;

   always_comb begin
      nz_cnt = 0;
      for (int i = 0; i < N_CELLS; i++)
         if (cell_cmd[2*i +: 2] != 2'b00) nz_cnt++;
      lvl_abs = (level < 0) ? -int'(level) : int'(level);
   end

   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (level == '0 && cell_cmd == '0 && !frozen));

   assert_level_range_R2: assert property (@(posedge clk) disable iff (rst)
      (int'(level) <= N_CELLS && int'(level) >= -N_CELLS));

   assert_active_count_R4: assert property (@(posedge clk) disable iff (rst)
      nz_cnt == lvl_abs);

   assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (rst)
      frozen |=> $stable(level) && $stable(cell_cmd));

   assert_sign_via_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (level > 0) |=> (level >= 0 || $past(rst)));

   for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_cell_chk
      assert_no_pos_to_neg_R5: assert property (@(posedge clk) disable iff (rst)
         (cell_cmd[2*gi +: 2] == 2'b01) |=> (cell_cmd[2*gi +: 2] != 2'b10));
      assert_no_neg_to_pos_R5: assert property (@(posedge clk) disable iff (rst)
         (cell_cmd[2*gi +: 2] == 2'b10) |=> (cell_cmd[2*gi +: 2] != 2'b01));
      assert_legal_code_R4: assert property (@(posedge clk) disable iff (rst)
         cell_cmd[2*gi +: 2] != 2'b11);
      if (gi > 0) begin : g_order
         assert_stack_order_R4: assert property (@(posedge clk) disable iff (rst)
            (cell_cmd[2*gi +: 2] != 2'b00) |-> (cell_cmd[2*(gi-1) +: 2] == cell_cmd[2*gi +: 2]));
      end
   end
endmodule

bind chb_stair_mod chb_stair_mod_chk #(.N_CELLS(N_CELLS), .LVL_W(LVL_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .level    (level),
   .cell_cmd (cell_cmd),
   .frozen   (frozen)
);

// File: tb/tb_chb_stair_mod.sv
module tb_chb_stair_mod;
   localparam int NC = 12;
   localparam int LW = $clog2(NC + 1) + 1;

   logic                 clk = 1'b0;
   logic                 rst;
   logic signed [15:0]   ref_in;
   logic [15:0]          hold_cycles;
   logic [15:0]          min_gap;
   logic signed [LW-1:0] level;
   logic [2*NC-1:0]      cell_cmd;
   logic                 frozen;

   int n_chk  = 0;
   int n_fail = 0;
   int model_lvl = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   chb_stair_mod dut (
      .clk(clk), .rst(rst), .ref_in(ref_in), .hold_cycles(hold_cycles),
      .min_gap(min_gap), .level(level), .cell_cmd(cell_cmd), .frozen(frozen)
   );

   function automatic logic [2*NC-1:0] cells_for(int lvl);
      logic [2*NC-1:0] v = '0;
      for (int i = 0; i < NC; i++) begin
         if (lvl >= i + 1)       v[2*i +: 2] = 2'b01;
         else if (lvl <= -i - 1) v[2*i +: 2] = 2'b10;
      end
      return v;
   endfunction

   function automatic int round_lvl(int v);
      int m = (v < 0) ? -v : v;
      int k = (m + 200) / 400;
      if (k > NC) k = NC;
      return (v < 0) ? -k : k;
   endfunction

   task automatic check(string req, int exp_lvl, bit exp_frz);
      n_chk++;
      if (int'(level) != exp_lvl || cell_cmd != cells_for(exp_lvl) || frozen != exp_frz) begin
         n_fail++;
         $display("FAIL %s: level=%0d cells=%h frozen=%0b expected level=%0d cells=%h frozen=%0b",
                  req, int'(level), cell_cmd, frozen, exp_lvl, cells_for(exp_lvl), exp_frz);
      end
   endtask

   // One clock edge per call; the bench always sits at a falling edge.
   task automatic apply(int v);
      ref_in = 16'(v);
      @(negedge clk);
   endtask

   // Guard-off model step including the zero-crossing rule.
   task automatic model_step(string req, int v);
      int t = round_lvl(v);
      if ((model_lvl > 0 && t < 0) || (model_lvl < 0 && t > 0)) t = 0;
      apply(v);
      model_lvl = t;
      check(req, t, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst = 1'b1; ref_in = 16'sd3000; hold_cycles = '0; min_gap = '0;
      repeat (3) @(negedge clk);
      check("R8 reset", 0, 1'b0);
      rst = 1'b0;

      // R1 sweep across full scale, guard off
      for (int v = -5000; v <= 5000; v += 25) model_step("R1 sweep", v);
      // R1 midpoint thresholds: just below, exactly on, just above
      for (int k = -13; k <= 12; k++) begin
         model_step("R1 tie", k*400 + 199);
         model_step("R1 tie", k*400 + 200);
         model_step("R1 tie", k*400 + 201);
      end
      model_step("R1 first cell", 0);
      model_step("R1 first cell", 199);
      model_step("R1 first cell", 200);

      // R3 multi-level jumps
      model_step("R3 jump", 0);
      model_step("R3 jump", 4800);
      model_step("R3 jump", 400);
      model_step("R3 jump", 3600);

      // R5 zero crossing
      apply(2000);  model_lvl = 5;   check("R5 setup", 5, 1'b0);
      apply(-2000); model_lvl = 0;   check("R5 via zero", 0, 1'b0);
      apply(-2000); model_lvl = -5;  check("R5 after zero", -5, 1'b0);
      apply(4800);  model_lvl = 0;   check("R5 via zero", 0, 1'b0);
      apply(4800);  model_lvl = 12;  check("R5 after zero", 12, 1'b0);

      // R2 saturation
      model_step("R2 sat", 9000);
      model_step("R2 sat", 32767);
      model_step("R2 sat", -9000);
      model_step("R2 sat", -9000);
      model_step("R2 sat", -32768);
      model_step("R2 sat", 4999);

      // R8 mid-run reset
      rst = 1'b1;
      apply(4000);
      check("R8 mid reset", 0, 1'b0);
      rst = 1'b0;
      model_lvl = 0;
      model_step("R8 after reset", 0);

      // R6/R7 guard, min_gap = 4, hold = 5
      repeat (6) apply(0);
      min_gap = 16'd4; hold_cycles = 16'd5;
      apply(800);  check("R6 setup", 2, 1'b0);
      apply(800);  check("R6 setup", 2, 1'b0);
      apply(400);  check("R6 reversal frozen", 2, 1'b1);
      apply(4000); check("R6 ignored while frozen", 2, 1'b1);
      apply(-3000);check("R6 ignored while frozen", 2, 1'b1);
      apply(400);  check("R6 frozen", 2, 1'b1);
      apply(400);  check("R6 frozen last", 2, 1'b1);
      apply(400);  check("R6 released, held", 2, 1'b0);
      apply(400);  check("R6 move taken", 1, 1'b0);
      // reversal exactly min_gap edges after the move
      apply(400);  apply(400); apply(400);
      check("R6 boundary setup", 1, 1'b0);
      apply(1200); check("R6 boundary frozen", 1, 1'b1);
      repeat (4) apply(1200);
      check("R6 boundary frozen end", 1, 1'b1);
      apply(1200); check("R6 boundary released", 1, 1'b0);
      apply(1200); check("R6 boundary taken", 3, 1'b0);
      // reversal min_gap+1 edges after the move
      repeat (4) apply(1200);
      check("R7 setup", 3, 1'b0);
      apply(0);    check("R7 late reversal accepted", 0, 1'b0);

      finish_run();
   end
endmodule